// File: doc/BRIEF.md
# Streaming Component Feature Merger

This block keeps the running feature vector of every live connected component in a raster-scanned binary image, one pixel per clock cycle. A feature vector is the component's area and its bounding box (lowest and highest x, lowest and highest y). The block runs beside a separate link processor and window former. Those units supply the events for each pixel: run boundaries on the current and previous rows, node indices, the index that a retiring node merges into, and a flag saying that a retiring node has no outgoing link.

Pixels of a run on the current row are combined in an accumulator. When the run ends, the result is stored in a node-indexed table. When a run on the previous row begins, its node's vector is fetched and held. When that node retires, the held vector goes to one of three places. It is folded into the accumulator if the current row pixel is set. Otherwise it is folded into the table entry named by the merge index, using a read in one cycle and a write-back in the next. If the node has no outgoing link, the vector is emitted as a finished component on a strobe that is valid only.

Top module: `feat_merge`

## Requirements
- R1: After reset `compValid` is low, and it stays low until a retirement with no outgoing link occurs.
- R2: On every cycle with `pixOn` high, the pixel (`pixX`,`pixY`) joins the current run. On the cycle with `pixOn` and `runEnd` both high, the run's area (pixel count) and bounding box are written to table entry `runIdx`, and the accumulator starts empty for the next run.
- R3: `prevStart` with `prevIdx` loads that entry into a holding register on the next clock edge. A `retire` with `pixOn` low and `noLink` high, presented at least one cycle after that load, makes `compValid` high on the next cycle for exactly that cycle, with the held vector on the component outputs.
- R4: A `retire` with `pixOn` high merges the held vector into the current run. `noLink` is ignored in that case and nothing is emitted.
- R5: A `retire` with `pixOn` low and `noLink` low reads entry `mergeIdx`, combines it with the held vector, and writes the result back on the following cycle. Nothing is emitted.
- R6: A read of an entry in the same cycle as a write to that entry returns the new value. This covers two merges into one index on consecutive cycles, and a fetch of an entry in the cycle its write-back lands.
- R7: Area saturates at 2^AREA_W-1 in both run accumulation and merging.
- R8: Combining two vectors takes the minimum of the low bounds and the maximum of the high bounds, and adds the areas.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixX | input | X_W | Column of the current pixel |
| pixY | input | Y_W | Row of the current pixel |
| pixOn | input | 1 | Current row pixel is object |
| runEnd | input | 1 | Current pixel is the last of its run |
| runIdx | input | IDX_W | Node index of the current row run |
| prevStart | input | 1 | A previous-row run begins |
| prevIdx | input | IDX_W | Node index of that previous-row run |
| retire | input | 1 | The held previous-row node retires |
| noLink | input | 1 | The retiring node has no outgoing link |
| mergeIdx | input | IDX_W | Entry to merge into when the current pixel is background |
| compValid | output | 1 | A completed component is on the outputs |
| compMinX | output | X_W | Lowest column |
| compMaxX | output | X_W | Highest column |
| compMinY | output | Y_W | Lowest row |
| compMaxY | output | Y_W | Highest row |
| compArea | output | AREA_W | Pixel count, saturating |

## Verification
The main function is tried with multi-pixel and single-pixel runs stored and read back by emission, which separates plain accumulation from the bounding-box update. A retirement under an object pixel and another over background separate the accumulator path from the read-modify-write path. Two back-to-back merges into one entry, and a fetch of an entry in the very cycle its write-back lands, tell forwarding apart from a stale table read. A run longer than the area range shows whether the count saturates or wraps. A retirement whose no-link flag is raised over an object pixel shows that the flag is ignored there.

// File: rtl/feat_merge_pkg.sv
package feat_merge_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic runWrite;      // store finished current-row run
    logic prevRead;      // fetch previous-row node into holding register
    logic accMergePrev;  // fold held vector into the current run
    logic mergeRead;     // read merge target entry
    logic wbEn;          // write back combined merge target
    logic emit;          // present held vector as finished component
  } fmStrobe_t;

endpackage

// File: rtl/feat_merge_ctrl.sv
module feat_merge_ctrl
  import feat_merge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pixOn,
  input  logic      runEnd,
  input  logic      prevStart,
  input  logic      retire,
  input  logic      noLink,
  output fmStrobe_t strb
);

  logic pendQ;

  always_comb begin
    strb.runWrite     = pixOn & runEnd;
    strb.prevRead     = prevStart;
    strb.accMergePrev = retire & pixOn;
    strb.mergeRead    = retire & ~pixOn & ~noLink;
    strb.emit         = retire & ~pixOn & noLink;
    strb.wbEn         = pendQ;
  end

  // Read-modify-write: write-back one cycle after the read
  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= retire & ~pixOn & ~noLink;
  end

endmodule

// File: rtl/feat_merge_dp.sv
module feat_merge_dp
  import feat_merge_pkg::*;
#(
  parameter int X_W    = 8,
  parameter int Y_W    = 8,
  parameter int AREA_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmStrobe_t         strb,
  input  logic [X_W-1:0]    pixX,
  input  logic [Y_W-1:0]    pixY,
  input  logic              pixOn,
  input  logic [IDX_W-1:0]  runIdx,
  input  logic [IDX_W-1:0]  prevIdx,
  input  logic [IDX_W-1:0]  mergeIdx,
  output logic [IDX_W-1:0]  wbIdx,
  output logic              compValid,
  output logic [FW_OUT-1:0] compFeat
);

  localparam int FW     = AREA_W + 2*X_W + 2*Y_W;
  localparam int FW_OUT = FW;
  localparam int DEPTH  = 1 << IDX_W;
  // Field offsets in the packed vector {area, maxY, minY, maxX, minX}
  localparam int O_MNX = 0;
  localparam int O_MXX = X_W;
  localparam int O_MNY = 2*X_W;
  localparam int O_MXY = 2*X_W + Y_W;
  localparam int O_AR  = 2*X_W + 2*Y_W;
  localparam logic [FW-1:0] EMPTY_F =
    {{AREA_W{1'b0}}, {Y_W{1'b0}}, {Y_W{1'b1}}, {X_W{1'b0}}, {X_W{1'b1}}};

  function automatic logic [FW-1:0] combine(input logic [FW-1:0] a, input logic [FW-1:0] b);
    logic [X_W-1:0]    mnx, mxx;
    logic [Y_W-1:0]    mny, mxy;
    logic [AREA_W:0]   sum;
    logic [AREA_W-1:0] ar;
    mnx = (a[O_MNX +: X_W] < b[O_MNX +: X_W]) ? a[O_MNX +: X_W] : b[O_MNX +: X_W];
    mxx = (a[O_MXX +: X_W] > b[O_MXX +: X_W]) ? a[O_MXX +: X_W] : b[O_MXX +: X_W];
    mny = (a[O_MNY +: Y_W] < b[O_MNY +: Y_W]) ? a[O_MNY +: Y_W] : b[O_MNY +: Y_W];
    mxy = (a[O_MXY +: Y_W] > b[O_MXY +: Y_W]) ? a[O_MXY +: Y_W] : b[O_MXY +: Y_W];
    sum = {1'b0, a[O_AR +: AREA_W]} + {1'b0, b[O_AR +: AREA_W]};
    ar  = sum[AREA_W] ? {AREA_W{1'b1}} : sum[AREA_W-1:0];
    return {ar, mxy, mny, mxx, mnx};
  endfunction

  function automatic logic [FW-1:0] pixelFeat(input logic [X_W-1:0] x, input logic [Y_W-1:0] y);
    return {AREA_W'(1), y, y, x, x};
  endfunction

  logic [FW-1:0]    tbl [DEPTH];
  logic [FW-1:0]    accQ, accBase, accPix, accNext;
  logic             accOpenQ;
  logic [FW-1:0]    heldQ;
  logic [FW-1:0]    mergeRdQ, mergeHeldQ, wbData;
  logic [IDX_W-1:0] wbIdxQ;
  logic [FW-1:0]    fwdPrev, fwdMerge;

  // Current-row run accumulator
  always_comb begin
    accBase = accOpenQ ? accQ : EMPTY_F;
    accPix  = pixOn ? combine(accBase, pixelFeat(pixX, pixY)) : accBase;
    accNext = strb.accMergePrev ? combine(accPix, heldQ) : accPix;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= EMPTY_F;
      accOpenQ <= 1'b0;
    end else begin
      accQ     <= accNext;
      accOpenQ <= pixOn & ~strb.runWrite;
    end
  end

  // Merge write-back data
  assign wbData = combine(mergeRdQ, mergeHeldQ);
  assign wbIdx  = wbIdxQ;

  // Read ports with forwarding of the writes landing this cycle
  always_comb begin
    if (strb.wbEn && prevIdx == wbIdxQ)          fwdPrev = wbData;
    else if (strb.runWrite && prevIdx == runIdx) fwdPrev = accNext;
    else                                         fwdPrev = tbl[prevIdx];
    if (strb.wbEn && mergeIdx == wbIdxQ)          fwdMerge = wbData;
    else if (strb.runWrite && mergeIdx == runIdx) fwdMerge = accNext;
    else                                          fwdMerge = tbl[mergeIdx];
  end

  // Node-indexed feature table, two write sources on distinct indices
  always_ff @(posedge clk) begin
    if (strb.runWrite) tbl[runIdx] <= accNext;
    if (strb.wbEn)     tbl[wbIdxQ] <= wbData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ      <= EMPTY_F;
      mergeRdQ   <= EMPTY_F;
      mergeHeldQ <= EMPTY_F;
      wbIdxQ     <= '0;
    end else begin
      if (strb.prevRead) heldQ <= fwdPrev;
      if (strb.mergeRead) begin
        mergeRdQ   <= fwdMerge;
        mergeHeldQ <= heldQ;
        wbIdxQ     <= mergeIdx;
      end
    end
  end

  // Completed component output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      compValid <= 1'b0;
      compFeat  <= EMPTY_F;
    end else begin
      compValid <= strb.emit;
      if (strb.emit) compFeat <= heldQ;
    end
  end

endmodule

// File: rtl/feat_merge.sv
module feat_merge
  import feat_merge_pkg::*;
#(
  parameter int X_W    = 8,
  parameter int Y_W    = 8,
  parameter int AREA_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [X_W-1:0]    pixX,
  input  logic [Y_W-1:0]    pixY,
  input  logic              pixOn,
  input  logic              runEnd,
  input  logic [IDX_W-1:0]  runIdx,
  input  logic              prevStart,
  input  logic [IDX_W-1:0]  prevIdx,
  input  logic              retire,
  input  logic              noLink,
  input  logic [IDX_W-1:0]  mergeIdx,
  output logic              compValid,
  output logic [X_W-1:0]    compMinX,
  output logic [X_W-1:0]    compMaxX,
  output logic [Y_W-1:0]    compMinY,
  output logic [Y_W-1:0]    compMaxY,
  output logic [AREA_W-1:0] compArea
);

  localparam int FW = AREA_W + 2*X_W + 2*Y_W;

  fmStrobe_t        strb;
  logic [FW-1:0]    compFeat;
  logic [IDX_W-1:0] wbIdx;
  logic             wbEnSig;

  assign wbEnSig = strb.wbEn;

  feat_merge_ctrl ctrlU (
    .clk(clk), .rstN(rstN), .pixOn(pixOn), .runEnd(runEnd),
    .prevStart(prevStart), .retire(retire), .noLink(noLink), .strb(strb)
  );

  feat_merge_dp #(.X_W(X_W), .Y_W(Y_W), .AREA_W(AREA_W), .IDX_W(IDX_W)) dpU (
    .clk(clk), .rstN(rstN), .strb(strb), .pixX(pixX), .pixY(pixY), .pixOn(pixOn),
    .runIdx(runIdx), .prevIdx(prevIdx), .mergeIdx(mergeIdx), .wbIdx(wbIdx),
    .compValid(compValid), .compFeat(compFeat)
  );

  assign {compArea, compMaxY, compMinY, compMaxX, compMinX} = compFeat;

endmodule

// File: rtl/feat_merge_chk.sv
module feat_merge_chk #(
  parameter int X_W    = 8,
  parameter int AREA_W = 16,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              pixOn,
  input logic              runEnd,
  input logic [IDX_W-1:0]  runIdx,
  input logic              retire,
  input logic              noLink,
  input logic              wbEnSig,
  input logic [IDX_W-1:0]  wbIdx,
  input logic              compValid,
  input logic [X_W-1:0]    compMinX,
  input logic [X_W-1:0]    compMaxX,
  input logic [AREA_W-1:0] compArea
);

  // R3
  emit_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !pixOn && noLink) |=> compValid);

  // R1
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    compValid |-> $past(retire && !pixOn && noLink));

  // R5
  writeback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !pixOn && !noLink) |=> wbEnSig);

  // R6
  write_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbEnSig && pixOn && runEnd) |-> (runIdx != wbIdx));

  // R2
  comp_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    compValid |-> (compArea != '0 && compMinX <= compMaxX));

endmodule

bind feat_merge feat_merge_chk #(.X_W(X_W), .AREA_W(AREA_W), .IDX_W(IDX_W)) chkU (
  .clk(clk), .rstN(rstN), .pixOn(pixOn), .runEnd(runEnd), .runIdx(runIdx),
  .retire(retire), .noLink(noLink), .wbEnSig(wbEnSig), .wbIdx(wbIdx),
  .compValid(compValid), .compMinX(compMinX), .compMaxX(compMaxX), .compArea(compArea)
);

// File: tb/feat_merge_test.sv
module feat_merge_test;

  localparam int CLK_PERIOD = 10;
  localparam int XW = 8;
  localparam int YW = 8;
  localparam int AW = 6;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [XW-1:0] pixX = '0;
  logic [YW-1:0] pixY = '0;
  logic pixOn = 1'b0, runEnd = 1'b0, prevStart = 1'b0, retire = 1'b0, noLink = 1'b0;
  logic [IW-1:0] runIdx = '0, prevIdx = '0, mergeIdx = '0;
  logic compValid;
  logic [XW-1:0] compMinX, compMaxX;
  logic [YW-1:0] compMinY, compMaxY;
  logic [AW-1:0] compArea;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  feat_merge #(.X_W(XW), .Y_W(YW), .AREA_W(AW), .IDX_W(IW)) uut (
    .clk(clk), .rstN(rstN), .pixX(pixX), .pixY(pixY), .pixOn(pixOn), .runEnd(runEnd),
    .runIdx(runIdx), .prevStart(prevStart), .prevIdx(prevIdx), .retire(retire),
    .noLink(noLink), .mergeIdx(mergeIdx), .compValid(compValid), .compMinX(compMinX),
    .compMaxX(compMaxX), .compMinY(compMinY), .compMaxY(compMaxY), .compArea(compArea)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn();
    pixOn = 0; runEnd = 0; prevStart = 0; retire = 0; noLink = 0;
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s compValid actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic checkFeat(input string req, input int mnx, input int mxx,
                           input int mny, input int mxy, input int ar);
    checks++;
    if (compValid !== 1'b1 || compMinX != mnx || compMaxX != mxx ||
        compMinY != mny || compMaxY != mxy || compArea != ar) begin
      failures++;
      $display("FAIL %s actual v=%0b x=%0d..%0d y=%0d..%0d a=%0d expected v=1 x=%0d..%0d y=%0d..%0d a=%0d",
               req, compValid, compMinX, compMaxX, compMinY, compMaxY, compArea,
               mnx, mxx, mny, mxy, ar);
    end
  endtask

  // One current-row pixel; runEnd marks the last of the run
  task automatic pix(input int x, input int y, input logic last, input int idx);
    clearIn();
    pixOn = 1; pixX = XW'(x); pixY = YW'(y); runEnd = last; runIdx = IW'(idx);
    tick();
    clearIn();
  endtask

  // Read an entry back through the emission path and compare
  task automatic fetch(input string req, input int idx, input int mnx, input int mxx,
                       input int mny, input int mxy, input int ar);
    clearIn(); prevStart = 1; prevIdx = IW'(idx); tick();
    clearIn(); retire = 1; noLink = 1; tick();
    clearIn();
    checkFeat(req, mnx, mxx, mny, mxy, ar);
    tick();
    checkBit({req, " single pulse"}, compValid, 1'b0);
  endtask

  task automatic testReset();
    checkBit("R1 reset", compValid, 1'b0);
    tick();
    checkBit("R1 idle", compValid, 1'b0);
  endtask

  task automatic testRuns();
    for (int x = 3; x <= 6; x++) pix(x, 2, x == 6, 5);
    fetch("R2 R8 multi-pixel run", 5, 3, 6, 2, 2, 4);
    pix(10, 4, 1'b1, 6);
    fetch("R3 single-pixel run", 6, 10, 10, 4, 4, 1);
  endtask

  task automatic testAccMerge();
    clearIn(); prevStart = 1; prevIdx = 5; tick();
    clearIn(); pixOn = 1; pixX = 7; pixY = 3; retire = 1; tick();
    checkBit("R4 no emit on merge into run", compValid, 1'b0);
    pix(8, 3, 1'b1, 7);
    fetch("R4 retire into accumulator", 7, 3, 8, 2, 3, 6);
  endtask

  task automatic testTableMerge();
    clearIn(); prevStart = 1; prevIdx = 6; tick();
    clearIn(); retire = 1; mergeIdx = 7; tick();
    clearIn(); tick();
    checkBit("R5 no emit on table merge", compValid, 1'b0);
    fetch("R5 R8 read-modify-write merge", 7, 3, 10, 2, 4, 7);
  endtask

  task automatic testForward();
    pix(20, 9, 1'b1, 1);
    pix(0, 0, 1'b1, 2);
    pix(15, 15, 1'b1, 3);
    clearIn(); prevStart = 1; prevIdx = 1; tick();
    clearIn(); retire = 1; mergeIdx = 3; prevStart = 1; prevIdx = 2; tick();
    clearIn(); retire = 1; mergeIdx = 3; tick();
    checkBit("R6 no emit during chained merge", compValid, 1'b0);
    clearIn(); prevStart = 1; prevIdx = 3; tick();
    clearIn(); retire = 1; noLink = 1; tick();
    clearIn();
    checkFeat("R6 forwarded back-to-back merges", 0, 20, 0, 15, 3);
    tick();
  endtask

  task automatic testNoLinkIgnored();
    clearIn(); prevStart = 1; prevIdx = 1; tick();
    clearIn(); pixOn = 1; pixX = 30; pixY = 20; runEnd = 1; runIdx = 9;
    retire = 1; noLink = 1; tick();
    clearIn();
    checkBit("R4 noLink ignored over object pixel", compValid, 1'b0);
    fetch("R4 merged despite noLink", 9, 20, 30, 9, 20, 2);
  endtask

  task automatic testSaturate();
    for (int x = 0; x < 70; x++) pix(x, 30, x == 69, 10);
    fetch("R7 run area saturates", 10, 0, 69, 30, 30, 63);
    clearIn(); prevStart = 1; prevIdx = 10; tick();
    clearIn(); retire = 1; mergeIdx = 6; tick();
    clearIn(); tick();
    fetch("R7 merged area saturates", 6, 0, 69, 4, 30, 63);
  endtask

  initial begin
    clearIn();
    repeat (3) tick();
    testReset();
    rstN = 1;
    tick();
    testReset();
    testRuns();
    testAccMerge();
    testTableMerge();
    testForward();
    testNoLinkIgnored();
    testSaturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule